// File: doc/BRIEF.md
# Zero-Crossing Timing Quality Detector

This block grades how cleanly a received signal's zero crossings line up with the recovered bit clock, and turns that into a single quality flag. For every crossing, the clock recovery loop gives the block a strobe and a signed phase error. The error is the distance, in 1/64ths of a bit, between the moment the crossing arrived and the moment the loop predicted. A crossing that lands close enough to its predicted time counts as good. Any other crossing counts as bad.

The flag rises only after an unbroken run of good crossings. It falls on any bad crossing. It also falls when crossings stop arriving for too long, measured in bit strobes. While the receiver is in powersave, the flag is held at 0. The flag's duty cycle therefore follows the signal-to-noise ratio of the link. Logic outside the block averages it into an error-rate estimate.

Top module: `zc_quality_det`

## Requirements
- R1: While the synchronous active-high `rst` is sampled 1, the run count and idle count clear, and `quality` reads 0 from the following cycle. After reset, four good crossings are needed before `quality` rises.
- R2: `xing_err` is a two's-complement phase error in units of 1/64 bit. A crossing is good when |`xing_err`| <= 8, so -8 and +8 are good. A crossing with magnitude 9 or more is bad, and this includes the most negative code.
- R3: `quality` goes to 1 in the cycle after the fourth consecutive good crossing strobe. It is still 0 after the third.
- R4: A bad crossing drives `quality` to 0 from the next cycle and clears the run. Four further good crossings are then needed.
- R5: Once 16 `bit_tick` strobes have passed with no crossing strobe, `quality` is 0 from the cycle after the 16th strobe and the run is cleared. After 15 strobes it is unchanged.
- R6: If a crossing strobe and a bit strobe arrive in the same cycle, the crossing wins. The idle count restarts from 0 and that bit strobe is not counted.
- R7: While `rx_psave` is 1, `quality` is 0 in that same cycle and both counts clear. Four good crossings are needed after powersave ends.
- R8: While good crossings keep arriving less than 16 bit strobes apart, `quality` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xing_vld | input | 1 | One-cycle strobe marking a received zero crossing |
| xing_err | input | ERR_W | Signed phase error of that crossing, in 1/64 bit |
| bit_tick | input | 1 | One-cycle strobe, once per recovered bit period |
| rx_psave | input | 1 | Receive powersave; forces the flag low |
| quality | output | 1 | Signal quality flag |

## Verification
Every effect of a crossing, a bit strobe or a reset passes through one register, so it shows on `quality` exactly one cycle after the edge that samples it. Powersave is the exception: it gates the output combinationally and acts in the same cycle. The bench drives inputs on the falling edge and compares `quality` on the next falling edge against a reference model. That model is advanced one step per rising edge, so each comparison falls in the cycle where the result is due. Random traffic is mixed with directed runs at the boundaries of the error window, the four-crossing run length and the 16-strobe timeout.

// File: rtl/zc_quality_det.sv
module zc_quality_det #(
  parameter int ERR_W    = 8,
  parameter int GOOD_LIM = 8,
  parameter int RUN_LEN  = 4,
  parameter int IDLE_MAX = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xing_vld,
  input  logic [ERR_W-1:0] xing_err,
  input  logic             bit_tick,
  input  logic             rx_psave,
  output logic             quality
);
  localparam int MAG_W = ERR_W + 1;
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam int IDL_W = $clog2(IDLE_MAX + 1);

  logic [MAG_W-1:0] err_ext, err_mag;
  logic             is_good;
  logic [RUN_W-1:0] run_q, run_d;
  logic [IDL_W-1:0] idle_q, idle_d;
  logic             flag_q;

  assign err_ext = {xing_err[ERR_W-1], xing_err};
  assign err_mag = err_ext[MAG_W-1] ? (~err_ext + 1'b1) : err_ext;
  assign is_good = err_mag <= MAG_W'(GOOD_LIM);

  always_comb begin
    run_d  = run_q;
    idle_d = idle_q;
    if (xing_vld) begin
      idle_d = '0;
      if (!is_good)
        run_d = '0;
      else if (run_q != RUN_W'(RUN_LEN))
        run_d = run_q + 1'b1;
    end else if (bit_tick && idle_q != IDL_W'(IDLE_MAX)) begin
      idle_d = idle_q + 1'b1;
      if (idle_q == IDL_W'(IDLE_MAX - 1))
        run_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || rx_psave) begin
      run_q  <= '0;
      idle_q <= '0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      idle_q <= idle_d;
      flag_q <= run_d == RUN_W'(RUN_LEN);
    end
  end

  assign quality = flag_q & ~rx_psave;
endmodule

// File: rtl/zc_quality_det_chk.sv
module zc_quality_det_chk #(
  parameter int ERR_W    = 8,
  parameter int GOOD_LIM = 8,
  parameter int IDLE_MAX = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             xing_vld,
  input logic [ERR_W-1:0] xing_err,
  input logic             bit_tick,
  input logic             rx_psave,
  input logic             quality
);
  int err_i, mag_i, gap;
  logic bad_x;

  assign err_i = int'($signed(xing_err));
  assign mag_i = (err_i < 0) ? -err_i : err_i;
  assign bad_x = xing_vld && (mag_i > GOOD_LIM);

  always_ff @(posedge clk) begin
    if (rst || rx_psave || xing_vld) gap <= 0;
    else if (bit_tick && gap < IDLE_MAX) gap <= gap + 1;
  end

  p_reset_low_r1: assert property (@(posedge clk) rst |=> !quality);
  p_bad_drops_r4: assert property (@(posedge clk) disable iff (rst) bad_x && !rx_psave |=> !quality);
  p_psave_low_r7: assert property (@(posedge clk) disable iff (rst) rx_psave |-> !quality);
  p_rise_cause_r3: assert property (@(posedge clk) disable iff (rst) $rose(quality) |-> $past(xing_vld) && !$past(bad_x));
  p_timeout_r5: assert property (@(posedge clk) disable iff (rst) gap >= IDLE_MAX |-> !quality);
endmodule

bind zc_quality_det zc_quality_det_chk #(
  .ERR_W(ERR_W), .GOOD_LIM(GOOD_LIM), .IDLE_MAX(IDLE_MAX)
) u_chk (
  .clk(clk), .rst(rst), .xing_vld(xing_vld), .xing_err(xing_err),
  .bit_tick(bit_tick), .rx_psave(rx_psave), .quality(quality)
);

// File: tb/zc_quality_det_bench.sv
`timescale 1ns/1ps
module zc_quality_det_bench;
  logic clk = 1'b0, rst = 1'b1, xing_vld = 1'b0, bit_tick = 1'b0, rx_psave = 1'b0;
  logic [7:0] xing_err = '0;
  logic quality;
  int n_run = 0, n_fail = 0;
  int m_run = 0, m_idle = 0;
  bit m_q = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  zc_quality_det u_zc_quality_det (
    .clk(clk), .rst(rst), .xing_vld(xing_vld), .xing_err(xing_err),
    .bit_tick(bit_tick), .rx_psave(rx_psave), .quality(quality)
  );

  function automatic bit good_fn(int e);
    return ((e < 0) ? -e : e) <= 8;
  endfunction

  function automatic void model_edge(bit r, bit v, int e, bit t, bit p);
    if (r || p) begin
      m_run = 0; m_idle = 0; m_q = 0;
    end else begin
      if (v) begin
        m_idle = 0;
        m_run = good_fn(e) ? ((m_run < 4) ? m_run + 1 : 4) : 0;
      end else if (t && m_idle < 16) begin
        m_idle++;
        if (m_idle == 16) m_run = 0;
      end
      m_q = (m_run == 4);
    end
  endfunction

  task automatic step(string tag, bit r, bit v, int e, bit t, bit p);
    bit exp;
    rst = r; xing_vld = v; xing_err = 8'(e); bit_tick = t; rx_psave = p;
    model_edge(r, v, e, t, p);
    @(posedge clk);
    @(negedge clk);
    exp = m_q && !p;
    n_run++;
    if (quality !== exp) begin
      n_fail++;
      $display("FAIL %s: quality=%0b expected %0b at %0t", tag, quality, exp, $time);
    end
  endtask

  task automatic goods(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 1, i % 9 - 4, 0, 0);
  endtask

  task automatic ticks(string tag, int n);
    for (int i = 0; i < n; i++) begin
      step(tag, 0, 0, 0, 1, 0);
      step(tag, 0, 0, 0, 0, 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5a7));
    @(negedge clk);
    step("R1", 1, 0, 0, 0, 0);
    step("R1", 1, 1, 0, 1, 0);
    step("R1", 0, 0, 0, 0, 0);
    goods("R1_R3", 3);
    step("R3", 0, 1, 0, 0, 0);
    step("R2", 0, 1, 8, 0, 0);
    step("R2", 0, 1, -8, 0, 0);
    step("R2_R4", 0, 1, 9, 0, 0);
    goods("R4", 3);
    step("R4", 0, 1, 1, 0, 0);
    step("R2", 0, 1, -9, 0, 0);
    goods("R2", 4);
    step("R2", 0, 1, -128, 0, 0);
    goods("R8", 4);
    ticks("R5", 15);
    step("R5", 0, 0, 0, 1, 0);
    step("R5", 0, 1, 0, 0, 0);
    goods("R6", 3);
    ticks("R6", 15);
    step("R6", 0, 1, 2, 1, 0);
    ticks("R6", 15);
    step("R6", 0, 0, 0, 1, 0);
    goods("R7", 4);
    step("R7", 0, 0, 0, 0, 1);
    step("R7", 0, 1, 0, 0, 1);
    step("R7", 0, 0, 0, 0, 0);
    goods("R7", 3);
    step("R7", 0, 1, 0, 0, 0);
    for (int c = 0; c < 4000; c++) begin
      bit v = ($urandom_range(0, 2) == 0);
      int e = ($urandom_range(0, 19) == 0) ? int'($signed(8'($urandom))) : $urandom_range(0, 22) - 11;
      bit t = (c % 4 == 0);
      bit p = ($urandom_range(0, 199) == 0);
      bit r = ($urandom_range(0, 999) == 0);
      step("R8", r, v, e, t, p);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule